// File: doc/BRIEF.md
# Prioritized Interrupt Collector

The collector gathers a wide set of level-sensitive interrupt lines and folds them into one request line toward a processor. Each source owns a small control word holding an enable bit and a priority level. Software never writes that word directly. It writes a bit mask to a set alias, which ORs the mask into the word, or to a clear alias, which removes the mask bits from the word. Each cycle the block picks a winner among the sources that are both enabled and high: the highest level wins, and within one level the lowest source number wins. The winner's number is registered and readable through a status register.

A handler reads the status register to learn which source to serve. It then writes the vector register, which puts the winner's level in service. While a level is in service, requests at that level or below are held back, so only a strictly higher level can raise the request line. The handler ends by writing a one-hot level mask to the level-acknowledge register, which takes the level out of service. A soft-reset write to the control register returns every source word to zero, so every source is disabled and at level 0.

Top module: `irq_gather`

## Requirements
- R1: A write of mask M to the set alias of source n, at offset 0x124 + n*0x10, leaves that source's control word equal to its old value OR M (low 3 bits). The word reads back at offsets 0x120, 0x124 or 0x128 + n*0x10, with the level in bits 1:0 and the enable in bit 2.
- R2: A write of mask M to the clear alias of source n, at offset 0x128 + n*0x10, leaves that word equal to its old value AND NOT M. No other source's word changes.
- R3: A source whose enable bit (bit 2) is clear never becomes the winner and never raises irq_o, even while its input is high.
- R4: A read of offset 0x70 returns, in bits 6:0, the number of the winning enabled pending source: highest level first, then lowest number within a level. When no source qualifies, the read returns 0x7F.
- R5: irq_o is high exactly when a winner exists and no level at or above the winner's level is in service. It follows a change of source input or control word by one clock cycle.
- R6: A write to offset 0x00 puts the level of the current winner in service.
- R7: A write to offset 0x10 with a one-hot mask takes every level whose bit is set out of service (0x1 releases level 0). Levels whose bit is clear keep their state.
- R8: A write to offset 0x20 with bit 31 set clears every source control word: all enables off and all levels 0.
- R9: Sources are level-sensitive. A source stops taking part in arbitration once its input goes low, and no write is needed for that.
- R10: Read data appears on bus_rdata one cycle after the read strobe. Reads of unmapped offsets return 0.
- R11: After reset every control word is 0, no level is in service, irq_o is low and the status reads 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the processor |

## Verification
The arbiter is driven with a single pending source, two sources tied at one level and sources at different levels. These cases separate the level ordering from the number ordering and expose a reversed tie rule. A source that is high but disabled checks that the enable gates both the winner and the request. Nested vector and acknowledge writes, including an acknowledge of a level that is not in service, show whether blocking uses "at or below" the in-service level and whether an acknowledge leaves the other levels alone. Dropping inputs and a soft reset check that the status falls back to the next winner and then to the idle code.

// File: rtl/irq_gather_pkg.sv
`timescale 1ns/1ps
package irq_gather_pkg;
   // register offsets (software visible, fixed)
   localparam int OFF_VEC   = 'h000;
   localparam int OFF_ACK   = 'h010;
   localparam int OFF_CTRL  = 'h020;
   localparam int OFF_STAT  = 'h070;
   localparam int SRC_BASE  = 'h120;
   localparam int SRC_STEP  = 16;
   localparam int SUB_WORD  = 'h0;
   localparam int SUB_SET   = 'h4;
   localparam int SUB_CLR   = 'h8;
   // control word layout
   localparam int EN_BIT    = 2;
   localparam int CW        = EN_BIT + 1;
   // soft reset bit in the control register
   localparam int SOFT_BIT  = 31;
endpackage

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
module irq_src_bank
   import irq_gather_pkg::*;
#(
   parameter int NSRC  = 128,
   parameter int NUM_W = $clog2(NSRC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_set,
   input  logic                  wr_clr,
   input  logic [NUM_W-1:0]      idx,
   input  logic [CW-1:0]         wmask,
   input  logic                  soft_clr,
   output logic [NSRC*CW-1:0]    word_flat
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [CW-1:0] word_q;
      logic          hit;
      assign hit = (idx == NUM_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                word_q <= '0;
         else if (soft_clr)         word_q <= '0;
         else if (wr_set && hit)    word_q <= word_q | wmask;
         else if (wr_clr && hit)    word_q <= word_q & ~wmask;
      end
      assign word_flat[i*CW +: CW] = word_q;
   end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
   parameter int NSRC  = 128,
   parameter int NLVL  = 4,
   parameter int NUM_W = $clog2(NSRC),
   parameter int LVL_W = $clog2(NLVL)
) (
   input  logic [NSRC-1:0]        req,
   input  logic [NSRC*LVL_W-1:0]  lvl_flat,
   output logic                   win_vld,
   output logic [NUM_W-1:0]       win_num,
   output logic [LVL_W-1:0]       win_lvl
);
   localparam logic [NUM_W-1:0] IDLE = NUM_W'(NSRC - 1);

   logic [NLVL-1:0]       hit_vec;
   logic [NLVL*NUM_W-1:0] pos_flat;

   // one lowest-number-first encoder per priority level
   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      logic             hit_l;
      logic [NUM_W-1:0] pos_l;
      always_comb begin
         hit_l = 1'b0;
         pos_l = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && (lvl_flat[i*LVL_W +: LVL_W] == LVL_W'(g))) begin
               hit_l = 1'b1;
               pos_l = NUM_W'(i);
            end
         end
      end
      assign hit_vec[g]                  = hit_l;
      assign pos_flat[g*NUM_W +: NUM_W]  = pos_l;
   end

   // highest level with a hit wins
   always_comb begin
      win_vld = 1'b0;
      win_num = IDLE;
      win_lvl = '0;
      for (int l = 0; l < NLVL; l++) begin
         if (hit_vec[l]) begin
            win_vld = 1'b1;
            win_num = pos_flat[l*NUM_W +: NUM_W];
            win_lvl = LVL_W'(l);
         end
      end
   end
endmodule

// File: rtl/irq_service.sv
`timescale 1ns/1ps
module irq_service #(
   parameter int NLVL  = 4,
   parameter int LVL_W = $clog2(NLVL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_stb,
   input  logic              ack_stb,
   input  logic [NLVL-1:0]   ack_mask,
   input  logic              cur_vld,
   input  logic [LVL_W-1:0]  cur_lvl,
   output logic [NLVL-1:0]   ins_o,
   output logic              irq_o
);
   logic [NLVL-1:0] ins_q;
   logic            blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ins_q <= '0;
      else if (vec_stb && cur_vld) ins_q[cur_lvl] <= 1'b1;
      else if (ack_stb)            ins_q <= ins_q & ~ack_mask;
   end

   always_comb begin
      blocked = 1'b0;
      for (int l = 0; l < NLVL; l++)
         if (ins_q[l] && (LVL_W'(l) >= cur_lvl)) blocked = 1'b1;
   end

   assign ins_o = ins_q;
   assign irq_o = cur_vld && !blocked;
endmodule

// File: rtl/irq_gather.sv
`timescale 1ns/1ps
module irq_gather
   import irq_gather_pkg::*;
#(
   parameter int NSRC   = 128,
   parameter int NLVL   = 4,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   localparam int NUM_W   = $clog2(NSRC);
   localparam int LVL_W   = $clog2(NLVL);
   localparam int SRC_END = SRC_BASE + NSRC * SRC_STEP;

   // elaboration-time parameter checks
   if (NSRC < 2 || NSRC > 128)
      begin : g_bad_nsrc   $error("NSRC must be 2..128");        end
   if (NLVL < 2 || (1 << LVL_W) != NLVL || LVL_W > EN_BIT)
      begin : g_bad_nlvl   $error("NLVL must be 2 or 4");        end
   if (SRC_END > (1 << ADDR_W))
      begin : g_bad_addr   $error("ADDR_W too small for map");   end

   // ---------------- decode ----------------
   logic              in_src;
   logic [ADDR_W-1:0] rel;
   logic [NUM_W-1:0]  idx;
   logic [3:0]        sub;
   logic              wr_set, wr_clr, vec_stb, ack_stb, soft_clr;

   assign in_src   = (int'(bus_addr) >= SRC_BASE) && (int'(bus_addr) < SRC_END);
   assign rel      = bus_addr - ADDR_W'(SRC_BASE);
   assign idx      = rel[NUM_W+3:4];
   assign sub      = rel[3:0];
   assign wr_set   = bus_wr && in_src && (sub == 4'(SUB_SET));
   assign wr_clr   = bus_wr && in_src && (sub == 4'(SUB_CLR));
   assign vec_stb  = bus_wr && (bus_addr == ADDR_W'(OFF_VEC));
   assign ack_stb  = bus_wr && (bus_addr == ADDR_W'(OFF_ACK));
   assign soft_clr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[SOFT_BIT];

   // ---------------- source words ----------------
   logic [NSRC*CW-1:0]    word_flat;
   logic [NSRC-1:0]       en_vec;
   logic [NSRC*LVL_W-1:0] lvl_flat;
   logic [NSRC-1:0]       req_vec;

   irq_src_bank #(.NSRC(NSRC), .NUM_W(NUM_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_set    (wr_set),
      .wr_clr    (wr_clr),
      .idx       (idx),
      .wmask     (bus_wdata[CW-1:0]),
      .soft_clr  (soft_clr),
      .word_flat (word_flat)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_split
      assign en_vec[i]                   = word_flat[i*CW + EN_BIT];
      assign lvl_flat[i*LVL_W +: LVL_W]  = word_flat[i*CW +: LVL_W];
   end
   assign req_vec = src_i & en_vec;

   // ---------------- arbitration ----------------
   logic             win_vld;
   logic [NUM_W-1:0] win_num;
   logic [LVL_W-1:0] win_lvl;

   irq_arbiter #(.NSRC(NSRC), .NLVL(NLVL), .NUM_W(NUM_W), .LVL_W(LVL_W)) u_arb (
      .req      (req_vec),
      .lvl_flat (lvl_flat),
      .win_vld  (win_vld),
      .win_num  (win_num),
      .win_lvl  (win_lvl)
   );

   logic             stat_vld_q;
   logic [NUM_W-1:0] stat_num_q;
   logic [LVL_W-1:0] stat_lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_vld_q <= 1'b0;
         stat_num_q <= NUM_W'(NSRC - 1);
         stat_lvl_q <= '0;
      end else begin
         stat_vld_q <= win_vld;
         stat_num_q <= win_num;
         stat_lvl_q <= win_lvl;
      end
   end

   // ---------------- in-service levels ----------------
   logic [NLVL-1:0] ins_vec;

   irq_service #(.NLVL(NLVL), .LVL_W(LVL_W)) u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec_stb  (vec_stb),
      .ack_stb  (ack_stb),
      .ack_mask (bus_wdata[NLVL-1:0]),
      .cur_vld  (stat_vld_q),
      .cur_lvl  (stat_lvl_q),
      .ins_o    (ins_vec),
      .irq_o    (irq_o)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_val;
   logic        sub_ok;

   assign sub_ok = (sub == 4'(SUB_WORD)) || (sub == 4'(SUB_SET)) || (sub == 4'(SUB_CLR));

   always_comb begin
      rd_val = '0;
      if (bus_addr == ADDR_W'(OFF_STAT))
         rd_val = 32'(stat_num_q);
      else if (in_src && sub_ok)
         rd_val = 32'(word_flat[idx*CW +: CW]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   logic unused_bits;
   assign unused_bits = ^{rel, bus_wdata};
endmodule

// File: rtl/irq_gather_chk.sv
`timescale 1ns/1ps
module irq_gather_chk
   import irq_gather_pkg::*;
#(
   parameter int NSRC   = 128,
   parameter int NLVL   = 4,
   parameter int ADDR_W = 12,
   parameter int NUM_W  = $clog2(NSRC),
   parameter int LVL_W  = $clog2(NLVL)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_o,
   input logic [NSRC-1:0]   req_vec,
   input logic [NSRC-1:0]   en_vec,
   input logic              stat_vld_q,
   input logic [NUM_W-1:0]  stat_num_q,
   input logic [LVL_W-1:0]  stat_lvl_q,
   input logic [NLVL-1:0]   ins_vec
);
   logic [NSRC-1:0] req_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= '0;
      else        req_d <= req_vec;
   end

   // R3: the registered winner was enabled and pending when captured
   a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld_q |-> req_d[stat_num_q]);

   // R4: with no winner the status holds the idle code
   a_r4_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_vld_q |-> (stat_num_q == NUM_W'(NSRC - 1)));

   // R5: a request needs a winner whose own level is free
   a_r5_irq_free_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (stat_vld_q && !ins_vec[stat_lvl_q]));

   // R6: a vector write marks the winner's level in service
   a_r6_vector_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_VEC) && stat_vld_q)
         |=> ins_vec[$past(stat_lvl_q)]);

   // R7: acknowledged levels leave service
   a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_ACK))
         |=> ((ins_vec & $past(bus_wdata[NLVL-1:0])) == '0));

   // R8: soft reset disables every source
   a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[SOFT_BIT])
         |=> (en_vec == '0));
endmodule

bind irq_gather irq_gather_chk #(
   .NSRC(NSRC), .NLVL(NLVL), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .irq_o      (irq_o),
   .req_vec    (req_vec),
   .en_vec     (en_vec),
   .stat_vld_q (stat_vld_q),
   .stat_num_q (stat_num_q),
   .stat_lvl_q (stat_lvl_q),
   .ins_vec    (ins_vec)
);

// File: tb/sim_irq_gather.sv
`timescale 1ns/1ps
module sim_irq_gather;
   localparam int NSRC = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src_i = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_gather u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [11:0] a_word(int n); return 12'('h120 + n*16); endfunction
   function automatic logic [11:0] a_set (int n); return 12'('h124 + n*16); endfunction
   function automatic logic [11:0] a_clr (int n); return 12'('h128 + n*16); endfunction

   // driver: writes
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   // driver: reads push the expected value for the monitor
   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_cmp++;
      if (irq_o !== e) begin
         n_bad++;
         $display("FAIL %s irq_o actual=%0b expected=%0b", t, irq_o, e);
      end
   endtask

   // monitor
   always @(posedge clk) rd_seen <= bus_rd;

   initial begin
      forever begin
         @(negedge clk);
         if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R11 reset state
      chk_irq(1'b0, "R11 reset irq");
      rd(12'h070, 32'h7F, "R11 reset status");
      rd(a_word(5), 32'h0, "R11 reset word");

      // R1 / R2 set and clear aliases
      wr(a_set(10), 32'h6);
      rd(a_word(10), 32'h6, "R1 set alias");
      wr(a_set(10), 32'h1);
      rd(a_word(10), 32'h7, "R1 set ORs");
      wr(a_clr(10), 32'h3);
      rd(a_set(10), 32'h4, "R2 clear alias");
      rd(a_word(11), 32'h0, "R2 neighbour untouched");
      wr(a_clr(10), 32'h4);

      // R3 disabled pending source
      @(negedge clk); src_i[3] = 1'b1;
      idle(2);
      chk_irq(1'b0, "R3 disabled source");
      rd(12'h070, 32'h7F, "R3 status idle");

      // R5 / R4 single enabled source, level 0
      wr(a_set(3), 32'h4);
      idle(2);
      chk_irq(1'b1, "R5 single source");
      rd(12'h070, 32'd3, "R4 single winner");

      // R4 tie at level 0: lowest number
      @(negedge clk); src_i[1] = 1'b1;
      wr(a_set(1), 32'h4);
      idle(2);
      rd(12'h070, 32'd1, "R4 tie lowest number");

      // R4 higher level wins
      @(negedge clk); src_i[100] = 1'b1;
      wr(a_set(100), 32'h6);
      idle(2);
      rd(12'h070, 32'd100, "R4 level 2 wins");

      // R6 vector write puts level 2 in service
      wr(12'h000, 32'h0);
      idle(2);
      chk_irq(1'b0, "R6 level 2 in service");

      // R5 strictly higher level passes
      @(negedge clk); src_i[50] = 1'b1;
      wr(a_set(50), 32'h7);
      idle(2);
      chk_irq(1'b1, "R5 level 3 above service");
      rd(12'h070, 32'd50, "R4 level 3 wins");

      // R9 drop the input
      @(negedge clk); src_i[50] = 1'b0;
      idle(2);
      chk_irq(1'b0, "R9 dropped source");
      rd(12'h070, 32'd100, "R9 status falls back");

      // R7 acknowledge level 2
      wr(12'h010, 32'h4);
      idle(2);
      chk_irq(1'b1, "R7 ack level 2");

      // R7 acknowledge of another level leaves level 2 in service
      wr(12'h000, 32'h0);
      wr(12'h010, 32'h1);
      idle(2);
      chk_irq(1'b0, "R7 ack other level ignored");
      wr(12'h010, 32'h4);
      idle(2);
      chk_irq(1'b1, "R7 ack level 2 again");

      // R9 remove level-2 source, winner back to 1 at level 0
      @(negedge clk); src_i[100] = 1'b0;
      idle(2);
      rd(12'h070, 32'd1, "R9 back to level 0");
      chk_irq(1'b1, "R5 level 0 with none in service");

      // R6 / R7 level 0 in service and released by 0x1
      wr(12'h000, 32'h0);
      idle(2);
      chk_irq(1'b0, "R6 level 0 in service");
      wr(12'h010, 32'h1);
      idle(2);
      chk_irq(1'b1, "R7 ack level 0");

      // R10 unmapped reads
      rd(12'h030, 32'h0, "R10 unmapped 0x30");
      rd(12'h12C, 32'h0, "R10 unmapped sub offset");
      rd(12'h924, 32'h0, "R10 past source range");

      // R8 soft reset
      wr(12'h020, 32'h8000_0000);
      rd(a_word(3), 32'h0, "R8 word 3 cleared");
      rd(a_word(100), 32'h0, "R8 word 100 cleared");
      idle(2);
      chk_irq(1'b0, "R8 irq after soft reset");
      rd(12'h070, 32'h7F, "R8 status idle");

      idle(4);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule